// File: doc/BRIEF.md
# Flash Write-Engine Status Register

This block keeps the 8-bit status word through which a host tracks the internal write engine of a flash device. It combines the engine's live readiness with two sticky fault flags (one for page programming, one for erasing) and a sector-protection indication. The host reads the word through the chip-enable and output-enable strobes. The word is frozen at the moment the read window opens, so it cannot change while the host is sampling it.

The fault flags remain set until the command decoder asks for them to be cleared. While either flag is set, the block refuses any new program or erase start request. An abort issued while the engine is busy counts as a fault of whichever operation was running. In word mode the upper data lines are driven to zero during a status read. In byte mode they are left undriven.

Top module: `flash_stat_reg`

## Requirements
- R1: Bit 7 of a status read is 1 when `eng_busy` was low at the moment the read window opened, and 0 when it was high.
- R2: Bit 4 (program fault) becomes 1 one clock after `eng_prog_fail` is high, or after `abort_req` is high while `eng_busy` is high and `eng_is_erase` is low. It then stays 1 until cleared.
- R3: Bit 5 (erase fault) becomes 1 one clock after `eng_erase_fail` is high, or after `abort_req` is high while `eng_busy` and `eng_is_erase` are both high. It then stays 1 until cleared.
- R4: A one-cycle `clr_req` resets bits 5 and 4. A fault event in the same cycle as the clear wins, so its bit stays set. The clear leaves bits 7 and 3 unchanged.
- R5: Bit 3 reflects `prot_any` at the moment the read window opened. Neither a clear nor the engine changes it.
- R6: Bits 6, 2, 1 and 0 always read 0.
- R7: After reset, with the engine idle, no faults and no protection, a status read returns 80h.
- R8: The status is captured when `ce_n` and `oe_n` are both low after at least one of them was high. While both stay low, `stat_data` does not change. A new value appears only after the window is closed and reopened.
- R9: During a read, `drive_lo` is 1. In word mode (`byte_mode`=0) `drive_hi` is 1 and bits above 7 are 0. In byte mode (`byte_mode`=1) `drive_hi` is 0.
- R10: `prog_go` equals `prog_req` and `erase_go` equals `erase_req` while both fault bits are 0. Both are forced to 0 while either fault bit is 1.
- R11: Outside a read window, `drive_lo` and `drive_hi` are 0 and `stat_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_busy | input | 1 | Write engine is working |
| eng_is_erase | input | 1 | Current engine job is an erase (0 = program) |
| eng_prog_fail | input | 1 | One-cycle program failure report |
| eng_erase_fail | input | 1 | One-cycle erase failure report |
| abort_req | input | 1 | Abort of the running job |
| prot_any | input | 1 | At least one protectable sector is locked |
| clr_req | input | 1 | One-cycle clear-status request |
| prog_req | input | 1 | Request to start a page program |
| erase_req | input | 1 | Request to start an erase |
| ce_n | input | 1 | Chip enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| byte_mode | input | 1 | 1 = byte-wide bus, 0 = word-wide bus |
| prog_go | output | 1 | Program start accepted |
| erase_go | output | 1 | Erase start accepted |
| stat_data | output | DATA_W | Status read data |
| drive_lo | output | 1 | Drive enable for data bits 7..0 |
| drive_hi | output | 1 | Drive enable for data bits above 7 |

## Verification
The bench builds the block with DATA_W=16 and SYNC_STAGES=2. This exercises the padded upper byte, the byte/word drive split and the synchronizer chain on the strobes. The synchronizer delay means a status change can fall between strobe edges, which makes the freeze property (R8) observable. Random fault, abort and clear traffic gives clear and fault events in the same cycle, as well as aborts of both job kinds.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
   localparam int STAT_W     = 8;
   localparam int BIT_READY  = 7;
   localparam int BIT_EFAIL  = 5;
   localparam int BIT_PFAIL  = 4;
   localparam int BIT_PROT   = 3;
   localparam logic [STAT_W-1:0] STAT_RESET = 8'h80;

   typedef struct packed {
      logic ready;
      logic efail;
      logic pfail;
      logic prot;
   } stat_fields_t;

   function automatic logic [STAT_W-1:0] pack_stat(stat_fields_t f);
      logic [STAT_W-1:0] w;
      w = '0;
      w[BIT_READY] = f.ready;
      w[BIT_EFAIL] = f.efail;
      w[BIT_PFAIL] = f.pfail;
      w[BIT_PROT]  = f.prot;
      return w;
   endfunction
endpackage

// File: rtl/flash_stat_sync.sv
module flash_stat_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_n,
   output logic q_n
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q_n = d_n;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2+((STAGES==1)?1:0):0], d_n} ;
         end
         assign q_n = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/flash_stat_faults.sv
module flash_stat_faults (
   input  logic clk,
   input  logic rst_n,
   input  logic eng_busy,
   input  logic eng_is_erase,
   input  logic eng_prog_fail,
   input  logic eng_erase_fail,
   input  logic abort_req,
   input  logic clr_req,
   output logic pfail,
   output logic efail
);
   logic abort_live;
   logic set_p, set_e;

   assign abort_live = abort_req & eng_busy;
   assign set_p = eng_prog_fail  | (abort_live & ~eng_is_erase);
   assign set_e = eng_erase_fail | (abort_live &  eng_is_erase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pfail <= 1'b0;
         efail <= 1'b0;
      end else begin
         pfail <= (pfail & ~clr_req) | set_p;
         efail <= (efail & ~clr_req) | set_e;
      end
   end
endmodule

// File: rtl/flash_stat_snap.sv
module flash_stat_snap #(
   parameter int W = 8,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         win,
   input  logic [W-1:0] live,
   output logic         win_q,
   output logic [W-1:0] snap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= 1'b0;
         snap  <= INIT;
      end else begin
         win_q <= win;
         if (win && !win_q) snap <= live;
      end
   end
endmodule

// File: rtl/flash_stat_reg.sv
module flash_stat_reg
   import flash_stat_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_busy,
   input  logic              eng_is_erase,
   input  logic              eng_prog_fail,
   input  logic              eng_erase_fail,
   input  logic              abort_req,
   input  logic              prot_any,
   input  logic              clr_req,
   input  logic              prog_req,
   input  logic              erase_req,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              byte_mode,
   output logic              prog_go,
   output logic              erase_go,
   output logic [DATA_W-1:0] stat_data,
   output logic              drive_lo,
   output logic              drive_hi
);
   localparam int PAD_W = DATA_W - STAT_W;

   generate
      if (DATA_W < STAT_W) begin : g_bad_width
         $error("flash_stat_reg: DATA_W must be at least 8");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("flash_stat_reg: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic ce_s_n, oe_s_n;
   logic pfail, efail;
   logic win_q;
   logic [STAT_W-1:0] live, snap;
   stat_fields_t fields;

   flash_stat_sync #(.STAGES(SYNC_STAGES)) i_sync_ce (
      .clk(clk), .rst_n(rst_n), .d_n(ce_n), .q_n(ce_s_n));
   flash_stat_sync #(.STAGES(SYNC_STAGES)) i_sync_oe (
      .clk(clk), .rst_n(rst_n), .d_n(oe_n), .q_n(oe_s_n));

   flash_stat_faults i_faults (
      .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy),
      .eng_is_erase(eng_is_erase), .eng_prog_fail(eng_prog_fail),
      .eng_erase_fail(eng_erase_fail), .abort_req(abort_req),
      .clr_req(clr_req), .pfail(pfail), .efail(efail));

   always_comb begin
      fields.ready = ~eng_busy;
      fields.efail = efail;
      fields.pfail = pfail;
      fields.prot  = prot_any;
      live = pack_stat(fields);
   end

   flash_stat_snap #(.W(STAT_W), .INIT(STAT_RESET)) i_snap (
      .clk(clk), .rst_n(rst_n), .win(~ce_s_n & ~oe_s_n),
      .live(live), .win_q(win_q), .snap(snap));

   assign prog_go  = prog_req  & ~(pfail | efail);
   assign erase_go = erase_req & ~(pfail | efail);
   assign drive_lo = win_q;
   assign drive_hi = win_q & ~byte_mode;

   generate
      if (PAD_W > 0) begin : g_wide
         assign stat_data = win_q ? {{PAD_W{1'b0}}, snap} : '0;
      end else begin : g_narrow
         assign stat_data = win_q ? snap : '0;
      end
   endgenerate
endmodule

module flash_stat_reg_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_req,
   input logic              prog_req,
   input logic              erase_req,
   input logic              byte_mode,
   input logic              pfail,
   input logic              efail,
   input logic              prog_go,
   input logic              erase_go,
   input logic [DATA_W-1:0] stat_data,
   input logic              drive_lo,
   input logic              drive_hi
);
   assert_sticky_pfail_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pfail) && !$past(clr_req)) |-> pfail);
   assert_sticky_efail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(efail) && !$past(clr_req)) |-> efail);
   assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drive_lo |-> (stat_data[6] == 1'b0 && stat_data[2:0] == 3'b000));
   assert_frozen_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_lo && $past(drive_lo)) |-> $stable(stat_data));
   assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      drive_lo |-> (stat_data >> 8) == '0);
   assert_hi_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      drive_hi |-> (drive_lo && !byte_mode));
   assert_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pfail || efail) |-> (!prog_go && !erase_go));
   assert_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!pfail && !efail) |-> (prog_go == prog_req && erase_go == erase_req));
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_lo |-> (stat_data == '0 && !drive_hi));
endmodule

bind flash_stat_reg flash_stat_reg_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .prog_req(prog_req),
   .erase_req(erase_req), .byte_mode(byte_mode), .pfail(pfail),
   .efail(efail), .prog_go(prog_go), .erase_go(erase_go),
   .stat_data(stat_data), .drive_lo(drive_lo), .drive_hi(drive_hi));

// File: tb/test_flash_stat_reg.sv
module test_flash_stat_reg;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 16;
   localparam int MAX_CYCLES = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eng_busy = 0, eng_is_erase = 0, eng_prog_fail = 0, eng_erase_fail = 0;
   logic abort_req = 0, prot_any = 0, clr_req = 0, prog_req = 0, erase_req = 0;
   logic ce_n = 1, oe_n = 1, byte_mode = 0;
   logic prog_go, erase_go, drive_lo, drive_hi;
   logic [DATA_W-1:0] stat_data;

   int checks = 0, failures = 0, cycles = 0;
   logic m_pf = 0, m_ef = 0;

   flash_stat_reg #(.DATA_W(DATA_W), .SYNC_STAGES(2)) i_flash_stat_reg (
      .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .eng_is_erase(eng_is_erase),
      .eng_prog_fail(eng_prog_fail), .eng_erase_fail(eng_erase_fail),
      .abort_req(abort_req), .prot_any(prot_any), .clr_req(clr_req),
      .prog_req(prog_req), .erase_req(erase_req), .ce_n(ce_n), .oe_n(oe_n),
      .byte_mode(byte_mode), .prog_go(prog_go), .erase_go(erase_go),
      .stat_data(stat_data), .drive_lo(drive_lo), .drive_hi(drive_hi));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [DATA_W-1:0] exp_stat(logic busy, logic ef, logic pf, logic pr);
      logic [DATA_W-1:0] v;
      v = '0;
      v[7] = ~busy; v[5] = ef; v[4] = pf; v[3] = pr;
      return v;
   endfunction

   task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock with the current inputs, then update the model; pulses return to 0
   task automatic step();
      logic sp, se;
      @(posedge clk);
      sp = eng_prog_fail  | (abort_req & eng_busy & ~eng_is_erase);
      se = eng_erase_fail | (abort_req & eng_busy &  eng_is_erase);
      m_pf = (m_pf & ~clr_req) | sp;
      m_ef = (m_ef & ~clr_req) | se;
      @(negedge clk);
      eng_prog_fail = 0; eng_erase_fail = 0; abort_req = 0; clr_req = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic read_check(string req);
      logic [DATA_W-1:0] e;
      e = exp_stat(eng_busy, m_ef, m_pf, prot_any);
      ce_n = 0; oe_n = 0;
      idle(5);
      check(req, stat_data, e);
      check("R9 drive_lo", {15'b0, drive_lo}, 16'd1);
      check("R9 drive_hi", {15'b0, drive_hi}, {15'b0, ~byte_mode});
      ce_n = 1; oe_n = 1;
      idle(5);
      check("R11 idle data", stat_data, '0);
      check("R11 idle drive", {14'b0, drive_hi, drive_lo}, '0);
   endtask

   task automatic gate_check();
      prog_req = 1; erase_req = 1;
      #1;
      check("R10 prog_go", {15'b0, prog_go}, {15'b0, ~(m_pf | m_ef)});
      check("R10 erase_go", {15'b0, erase_go}, {15'b0, ~(m_pf | m_ef)});
      prog_req = 0; erase_req = 0;
   endtask

   initial begin : watchdog
      while (cycles < MAX_CYCLES) begin
         @(posedge clk);
         cycles++;
      end
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [DATA_W-1:0] held;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R11 reset drive", {15'b0, drive_lo}, '0);
      rst_n = 1;
      idle(2);
      // R7 power-up value
      read_check("R7 reset value 80h");
      gate_check();

      // R1 busy shows 0 in bit 7
      eng_busy = 1; step(); read_check("R1 busy");
      // R2 abort during program
      abort_req = 1; eng_is_erase = 0; step(); read_check("R2 abort program");
      gate_check();
      // R5 protection visible, R4 clear leaves it
      prot_any = 1; clr_req = 1; step(); read_check("R4 R5 clear keeps prot");
      // R3 abort during erase, idle abort ignored
      eng_is_erase = 1; abort_req = 1; step();
      eng_busy = 0; abort_req = 1; step();
      read_check("R3 abort erase");
      // R4 clear and fault together: fault wins
      clr_req = 1; eng_prog_fail = 1; step();
      read_check("R4 set wins over clear");
      clr_req = 1; step(); read_check("R4 clear both");
      gate_check();

      // R8 freeze while window held
      ce_n = 0; idle(3); oe_n = 0; idle(5);
      held = stat_data;
      check("R8 opened value", held, exp_stat(eng_busy, m_ef, m_pf, prot_any));
      eng_busy = 1; prot_any = 0; eng_erase_fail = 1; step(); idle(4);
      check("R8 frozen value", stat_data, held);
      oe_n = 1; idle(5); oe_n = 0; idle(5);
      check("R8 value after reopen", stat_data, exp_stat(eng_busy, m_ef, m_pf, prot_any));
      ce_n = 1; oe_n = 1; idle(5);

      // R9 byte mode
      byte_mode = 1; read_check("R9 byte mode"); byte_mode = 0;
      clr_req = 1; eng_busy = 0; step();
      read_check("R6 R4 all clear");

      // random traffic
      for (int it = 0; it < 400; it++) begin
         eng_busy       = $urandom_range(0, 1);
         eng_is_erase   = $urandom_range(0, 1);
         prot_any       = $urandom_range(0, 1);
         eng_prog_fail  = ($urandom_range(0, 9) == 0);
         eng_erase_fail = ($urandom_range(0, 9) == 0);
         abort_req      = ($urandom_range(0, 7) == 0);
         clr_req        = ($urandom_range(0, 4) == 0);
         byte_mode      = $urandom_range(0, 1);
         step();
         if (it % 4 == 0) read_check("R1 R2 R3 R4 R5 R6 random read");
         if (it % 3 == 0) gate_check();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule